// File: doc/BRIEF.md
# Drift Hit Arrival-Time Flagger

This block follows the hit indicator of a single drift chamber cell, one sample per time bin. A bin is 48 ns long, there are two bins per beam crossing, and a one-cycle strobe marks each bin. Hits that are close together in time are taken to belong to one event. A gap of three empty bins or more separates two events.

The block makes two flags. The "new" flag marks the bin that holds the first hit of a hit sequence. The "valid" flag goes high ten bins later, which covers the longest possible drift time. It then stays high until the hit sequence has finished, and it is always high for at least one bin. Downstream pattern logic uses these flags to know when all hits of one event are present.

Top module: `drift_arrival_flagger`

## Requirements
- R1: A synchronous active-high reset clears both outputs and any pending countdown. The cell then counts as idle, so the first hit after reset raises new.
- R2: When a bin holds a hit and the three bins before it were empty (or the cell was idle), new is high for exactly that one bin. It drops at the next bin strobe unless that bin starts another sequence.
- R3: A hit that follows the previous hit after a gap of at most two empty bins is part of the same sequence and does not raise new.
- R4: Valid rises at the tenth bin strobe after the strobe that raised new. It is low in every bin before that.
- R5: Once valid is high, it stays high while the sequence is still open. It drops at the strobe of the bin that completes three consecutive empty bins. If the sequence had already ended before valid rose, valid is high for exactly one bin.
- R6: If a new sequence starts while a countdown is still running, the countdown restarts from the new start. The earlier window never produces valid.
- R7: The strobe that starts a new sequence forces valid low in that bin.
- R8: Both outputs and all internal state change only on cycles where the bin strobe is high. The hit input has no effect when the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bin_tick | input | 1 | One-cycle strobe marking the end of a time bin |
| hit | input | 1 | Cell hit indicator for the bin, sampled with bin_tick |
| new_flag | output | 1 | First hit of a sequence was seen in the latest bin |
| valid_flag | output | 1 | Maximum drift time has passed; sequence may be processed |

## Verification
Every output is a register that updates at the clock edge where bin_tick is high. So new is due one edge after the strobe of its hit bin, and valid is due one edge after the tenth strobe that follows. The bench drives each bin on a falling edge and holds bin_tick for one cycle. It samples both flags at the next falling edge, after the updating edge and before the next one. Idle cycles without a strobe are sampled in the same way to show that the flags hold.

// File: rtl/drift_flag_pkg.sv
package drift_flag_pkg;

    localparam int unsigned QUIET_BINS_DEF = 3;
    localparam int unsigned DRIFT_BINS_DEF = 10;

    typedef struct packed {
        logic tick;
        logic hit;
    } bin_sample_t;

    function automatic int unsigned sat_next(input int unsigned cur,
                                             input int unsigned lim,
                                             input logic        clr);
        if (clr)
            return 0;
        else if (cur >= lim)
            return lim;
        else
            return cur + 1;
    endfunction

endpackage

// File: rtl/drift_gap_tracker.sv
module drift_gap_tracker
    import drift_flag_pkg::*;
#(
    parameter int unsigned QUIET_BINS = QUIET_BINS_DEF
) (
    input  logic        clk,
    input  logic        rst,
    input  bin_sample_t smp,
    output logic        seq_start,
    output logic        seq_close,
    output logic        new_o
);
    localparam int unsigned QW = $clog2(QUIET_BINS + 1);

    logic [QW-1:0] quiet_cnt;
    logic          idle;

    assign idle      = (int'(quiet_cnt) == QUIET_BINS);
    assign seq_start = smp.tick && smp.hit && idle;
    assign seq_close = smp.tick && !smp.hit && (int'(quiet_cnt) >= QUIET_BINS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            quiet_cnt <= QW'(QUIET_BINS);
            new_o     <= 1'b0;
        end else if (smp.tick) begin
            quiet_cnt <= QW'(sat_next(int'(quiet_cnt), QUIET_BINS, smp.hit));
            new_o     <= seq_start;
        end
    end

    AST_NEW_ONE_BIN: assert property (@(posedge clk) disable iff (rst)
        (new_o && smp.tick && !smp.hit) |=> !new_o);                    // R2
    AST_GAP_NO_NEW: assert property (@(posedge clk) disable iff (rst)
        (smp.tick && smp.hit && !idle) |=> !new_o);                     // R3

endmodule

// File: rtl/drift_delay.sv
module drift_delay
    import drift_flag_pkg::*;
#(
    parameter int unsigned DRIFT_BINS = DRIFT_BINS_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic start,
    output logic fire
);
    localparam int unsigned CW = (DRIFT_BINS > 1) ? $clog2(DRIFT_BINS) : 1;

    logic [CW-1:0] cnt;
    logic          armed;

    assign fire = tick && armed && (cnt == '0) && !start;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (tick) begin
            if (start) begin
                cnt   <= CW'(DRIFT_BINS - 1);
                armed <= 1'b1;
            end else if (armed) begin
                if (cnt == '0)
                    armed <= 1'b0;
                else
                    cnt <= cnt - 1'b1;
            end
        end
    end

    AST_RESTART: assert property (@(posedge clk) disable iff (rst)
        start |=> (armed && int'(cnt) == DRIFT_BINS - 1));              // R6
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(cnt) && $stable(armed)));                    // R8

endmodule

// File: rtl/drift_valid_stretch.sv
module drift_valid_stretch (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic start,
    input  logic fire,
    input  logic seq_close,
    output logic valid_o
);
    always_ff @(posedge clk) begin
        if (rst)
            valid_o <= 1'b0;
        else if (tick) begin
            if (start)
                valid_o <= 1'b0;
            else if (fire)
                valid_o <= 1'b1;
            else if (valid_o && seq_close)
                valid_o <= 1'b0;
        end
    end

    AST_FIRE_SETS_VALID: assert property (@(posedge clk) disable iff (rst)
        (fire && !start) |=> valid_o);                                  // R4
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        start |=> !valid_o);                                            // R7
    AST_HOLD_OPEN: assert property (@(posedge clk) disable iff (rst)
        (valid_o && tick && !seq_close && !start) |=> valid_o);         // R5

endmodule

// File: rtl/drift_arrival_flagger.sv
module drift_arrival_flagger
    import drift_flag_pkg::*;
#(
    parameter int unsigned QUIET_BINS = QUIET_BINS_DEF,
    parameter int unsigned DRIFT_BINS = DRIFT_BINS_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic bin_tick,
    input  logic hit,
    output logic new_flag,
    output logic valid_flag
);
    bin_sample_t smp;
    logic        start;
    logic        close_bin;
    logic        fire;

    assign smp.tick = bin_tick;
    assign smp.hit  = hit;

    drift_gap_tracker #(.QUIET_BINS(QUIET_BINS)) u_gap (
        .clk       (clk),
        .rst       (rst),
        .smp       (smp),
        .seq_start (start),
        .seq_close (close_bin),
        .new_o     (new_flag)
    );

    drift_delay #(.DRIFT_BINS(DRIFT_BINS)) u_delay (
        .clk   (clk),
        .rst   (rst),
        .tick  (bin_tick),
        .start (start),
        .fire  (fire)
    );

    drift_valid_stretch u_valid (
        .clk       (clk),
        .rst       (rst),
        .tick      (bin_tick),
        .start     (start),
        .fire      (fire),
        .seq_close (close_bin),
        .valid_o   (valid_flag)
    );

    AST_TICK_GATED: assert property (@(posedge clk) disable iff (rst)
        !bin_tick |=> ($stable(new_flag) && $stable(valid_flag)));      // R8
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!new_flag && !valid_flag));                            // R1

endmodule

// File: tb/tb_drift_arrival_flagger.sv
`timescale 1ns/1ps
module tb_drift_arrival_flagger;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bin_tick = 1'b0;
    logic hit = 1'b0;
    logic new_flag, valid_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    drift_arrival_flagger dut (
        .clk(clk), .rst(rst), .bin_tick(bin_tick), .hit(hit),
        .new_flag(new_flag), .valid_flag(valid_flag)
    );

    // per bin: {hit, expected new, expected valid}
    localparam int NV = 43;
    localparam logic [2:0] VEC [NV] = '{
        3'b000, 3'b110, 3'b000, 3'b000, 3'b100, 3'b000, 3'b000, 3'b000,
        3'b000, 3'b000, 3'b000, 3'b001, 3'b000, 3'b110, 3'b100, 3'b000,
        3'b100, 3'b000, 3'b100, 3'b000, 3'b100, 3'b000, 3'b100, 3'b101,
        3'b001, 3'b001, 3'b000, 3'b110, 3'b000, 3'b000, 3'b000, 3'b110,
        3'b000, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000,
        3'b000, 3'b001, 3'b000
    };

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_bin(input logic h);
        @(negedge clk);
        hit = h;
        bin_tick = 1'b1;
        @(negedge clk);
        bin_tick = 1'b0;
        hit = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 new after reset", new_flag, 1'b0);
        chk("R1 valid after reset", valid_flag, 1'b0);
        rst = 1'b0;

        // table walk: R1 R2 R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            run_bin(VEC[i][2]);
            chk($sformatf("R2/R3 new bin %0d", i), new_flag, VEC[i][1]);
            chk($sformatf("R4/R5/R6 valid bin %0d", i), valid_flag, VEC[i][0]);
        end

        // R8: hit without strobe is ignored
        hit = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk("R8 no tick no new", new_flag, 1'b0);
        end
        hit = 1'b0;
        run_bin(1'b1);
        chk("R2 new on idle hit", new_flag, 1'b1);
        repeat (3) begin
            @(negedge clk);
            chk("R8 new held between ticks", new_flag, 1'b1);
        end
        for (int j = 0; j < 9; j++) run_bin(1'b0);
        chk("R2 new dropped", new_flag, 1'b0);
        chk("R4 valid not early", valid_flag, 1'b0);
        run_bin(1'b0);
        chk("R4 valid on tenth bin", valid_flag, 1'b1);
        run_bin(1'b1);
        chk("R7 start forces valid low", valid_flag, 1'b0);
        chk("R7 new on restart", new_flag, 1'b1);

        // R1: reset mid-countdown
        for (int j = 0; j < 3; j++) run_bin(1'b0);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 new cleared", new_flag, 1'b0);
        chk("R1 valid cleared", valid_flag, 1'b0);
        rst = 1'b0;
        for (int j = 0; j < 12; j++) begin
            run_bin(1'b0);
            chk("R1 countdown cleared", valid_flag, 1'b0);
        end
        run_bin(1'b1);
        chk("R1 first hit raises new", new_flag, 1'b1);

        done = 1'b1;
        finish_run();
    end

endmodule